// File: doc/BRIEF.md
# Page Protection and Fault Encoder

This block decides whether a single memory access may proceed once the page and segment attributes are known. Each request brings a segment entry (a no-execute bit and two protection-key bits, one for user code and one for supervisor code), the two-bit protection value of the page, the current privilege mode, the kind of access, a flag saying the translation lookup found no entry, and the effective address. The block chooses the key for the current privilege, turns the key and the protection value into read, write and execute rights, and checks the access against them.

The result appears one clock after the request. A permitted access raises `allow_o`. A denied access raises either the instruction-fault flag or the data-fault flag and presents a fixed 32-bit code that says why. A data fault also loads the effective address into a fault-address register, which keeps its value until the next data fault. An access-type code that means nothing raises an error flag in place of a decision.

Top module: `page_guard`

## Requirements
- R1: The key is segment bit 2 (user key) when `user_mode_i` is 1 and segment bit 1 (supervisor key) when it is 0. Segment bit 0 is the no-execute bit.
- R2: With key 0, protection values 0, 1 and 2 give read and write, and value 3 gives read only. `rights_o` is {read, write, execute}, with read in bit 2.
- R3: With key 1, protection value 0 gives no read or write, values 1 and 3 give read only, and value 2 gives read and write.
- R4: Execute right (bit 0 of `rights_o`) is set only when the no-execute bit is clear. A fetch from a no-execute segment raises `fault_instr_o` with code 0x10000000, and this check comes before the missing-translation check.
- R5: An access the rights do not cover (a load without read, a store without write) raises `fault_data_o` with code 0x0A000000 for a store and 0x08000000 for a load.
- R6: When `miss_i` is 1, a fetch raises `fault_instr_o` with code 0x40000000, a store raises `fault_data_o` with 0x42000000, and a load raises `fault_data_o` with 0x40000000.
- R7: In the cycle `fault_data_o` is raised, `fault_addr_o` shows the effective address of that request. Otherwise `fault_addr_o` keeps its value.
- R8: Access type is 0 load, 1 store, 2 fetch. Type 3 raises `illegal_o` with `allow_o`, both fault flags and `code_o` all zero.
- R9: Each result is valid one cycle after its request (`rsp_valid_o`). When no request was given, `allow_o`, the fault flags, `illegal_o`, `rights_o` and `code_o` are zero, and only one fault flag is ever raised at a time.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| seg_i | input | 3 | Segment entry: bit 2 user key, bit 1 supervisor key, bit 0 no-execute |
| pp_i | input | 2 | Page protection value |
| user_mode_i | input | 1 | 1 = user privilege, 0 = supervisor |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 illegal |
| miss_i | input | 1 | Translation lookup found no entry |
| eff_addr_i | input | AW | Effective address of the access |
| rsp_valid_o | output | 1 | Result present |
| allow_o | output | 1 | Access permitted |
| rights_o | output | 3 | Granted rights {read, write, execute} |
| fault_instr_o | output | 1 | Instruction storage fault |
| fault_data_o | output | 1 | Data storage fault |
| code_o | output | 32 | Fault reason code, zero when no fault |
| fault_addr_o | output | AW | Effective address of the most recent data fault |
| illegal_o | output | 1 | Undefined access type |

## Verification
On every cycle the assertions check that the two fault flags are never both raised, that a permitted access never has a fault or the error flag with it, that write right never comes without read, that execute right is absent for a no-execute segment, that an illegal type gives no decision, and that the fault address follows data faults and otherwise holds. Which protection value and key give which rights, which reason wins when several apply, and the exact code for each reason can only be shown by the bench's scenarios. These scenarios sweep every privilege, key, protection value, access type and no-execute setting, and then go through missing translations, illegal types and idle gaps.

// File: rtl/page_guard_pkg.sv
package page_guard_pkg;

    localparam int SEG_W  = 3;
    localparam int SEG_NX = 0;
    localparam int SEG_KS = 1;
    localparam int SEG_KU = 2;
    localparam int CODE_W = 32;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_BAD   = 2'd3
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    localparam logic [CODE_W-1:0] CODE_NX      = 32'h1000_0000;
    localparam logic [CODE_W-1:0] CODE_DENY_RD = 32'h0800_0000;
    localparam logic [CODE_W-1:0] CODE_DENY_WR = 32'h0A00_0000;
    localparam logic [CODE_W-1:0] CODE_MISS_RD = 32'h4000_0000;
    localparam logic [CODE_W-1:0] CODE_MISS_WR = 32'h4200_0000;

endpackage

// File: rtl/pg_rights.sv
module pg_rights
    import page_guard_pkg::*;
(
    input  logic [SEG_W-1:0] seg_i,
    input  logic             user_mode_i,
    input  logic [1:0]       pp_i,
    output rights_t          rights_o
);

    logic key;

    always_comb begin
        key = user_mode_i ? seg_i[SEG_KU] : seg_i[SEG_KS];
        rights_o.ex = ~seg_i[SEG_NX];
        if (!key) begin
            rights_o.rd = 1'b1;
            rights_o.wr = (pp_i != 2'd3);
        end else begin
            rights_o.rd = (pp_i != 2'd0);
            rights_o.wr = (pp_i == 2'd2);
        end
    end

endmodule

// File: rtl/pg_fault_enc.sv
module pg_fault_enc
    import page_guard_pkg::*;
(
    input  logic [1:0]        acc_i,
    input  rights_t           rights_i,
    input  logic              nx_i,
    input  logic              miss_i,
    output logic              permit_o,
    output logic              f_instr_o,
    output logic              f_data_o,
    output logic              bad_o,
    output logic [CODE_W-1:0] code_o
);

    acc_e acc;
    logic need;
    logic is_fetch;
    logic is_store;

    always_comb begin
        acc      = acc_e'(acc_i);
        is_fetch = (acc == ACC_FETCH);
        is_store = (acc == ACC_STORE);
        case (acc)
            ACC_LOAD:  need = rights_i.rd;
            ACC_STORE: need = rights_i.wr;
            ACC_FETCH: need = rights_i.ex;
            default:   need = 1'b0;
        endcase

        permit_o  = 1'b0;
        f_instr_o = 1'b0;
        f_data_o  = 1'b0;
        bad_o     = 1'b0;
        code_o    = '0;

        if (acc == ACC_BAD) begin
            bad_o = 1'b1;
        end else if (is_fetch && nx_i) begin
            f_instr_o = 1'b1;
            code_o    = CODE_NX;
        end else if (miss_i) begin
            if (is_fetch) begin
                f_instr_o = 1'b1;
                code_o    = CODE_MISS_RD;
            end else begin
                f_data_o = 1'b1;
                code_o   = is_store ? CODE_MISS_WR : CODE_MISS_RD;
            end
        end else if (!need) begin
            if (is_fetch) begin
                f_instr_o = 1'b1;
                code_o    = CODE_DENY_RD;
            end else begin
                f_data_o = 1'b1;
                code_o   = is_store ? CODE_DENY_WR : CODE_DENY_RD;
            end
        end else begin
            permit_o = 1'b1;
        end
    end

endmodule

// File: rtl/page_guard.sv
module page_guard
    import page_guard_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [1:0]        pp_i,
    input  logic              user_mode_i,
    input  logic [1:0]        acc_i,
    input  logic              miss_i,
    input  logic [AW-1:0]     eff_addr_i,
    output logic              rsp_valid_o,
    output logic              allow_o,
    output logic [2:0]        rights_o,
    output logic              fault_instr_o,
    output logic              fault_data_o,
    output logic [CODE_W-1:0] code_o,
    output logic [AW-1:0]     fault_addr_o,
    output logic              illegal_o
);

    typedef struct packed {
        logic              valid;
        logic              allow;
        rights_t           rights;
        logic              fi;
        logic              fd;
        logic [CODE_W-1:0] code;
        logic [AW-1:0]     faddr;
        logic              bad;
    } state_t;

    state_t  st_d, st_q;
    rights_t rights_c;
    logic    permit_c, fi_c, fd_c, bad_c;
    logic [CODE_W-1:0] code_c;

    pg_rights u_rights (
        .seg_i       (seg_i),
        .user_mode_i (user_mode_i),
        .pp_i        (pp_i),
        .rights_o    (rights_c)
    );

    pg_fault_enc u_enc (
        .acc_i     (acc_i),
        .rights_i  (rights_c),
        .nx_i      (seg_i[SEG_NX]),
        .miss_i    (miss_i),
        .permit_o  (permit_c),
        .f_instr_o (fi_c),
        .f_data_o  (fd_c),
        .bad_o     (bad_c),
        .code_o    (code_c)
    );

    always_comb begin
        st_d       = '0;
        st_d.faddr = st_q.faddr;
        if (req_valid_i) begin
            st_d.valid  = 1'b1;
            st_d.allow  = permit_c;
            st_d.rights = rights_c;
            st_d.fi     = fi_c;
            st_d.fd     = fd_c;
            st_d.code   = code_c;
            st_d.bad    = bad_c;
            if (fd_c) begin
                st_d.faddr = eff_addr_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o   = st_q.valid;
    assign allow_o       = st_q.allow;
    assign rights_o      = st_q.rights;
    assign fault_instr_o = st_q.fi;
    assign fault_data_o  = st_q.fd;
    assign code_o        = st_q.code;
    assign fault_addr_o  = st_q.faddr;
    assign illegal_o     = st_q.bad;

    p_one_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_instr_o && fault_data_o));

    p_allow_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        allow_o |-> (!fault_instr_o && !fault_data_o && !illegal_o && code_o == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> (!allow_o && !fault_instr_o && !fault_data_o && !illegal_o));

    p_write_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rights_o[1] |-> rights_o[2]);

    p_nx_no_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(seg_i[SEG_NX])) |-> !rights_o[0]);

    p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && acc_i == 2'd3) |=> (illegal_o && !allow_o && !fault_instr_o && !fault_data_o));

    p_faddr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_data_o |-> (fault_addr_o == $past(eff_addr_i)));

    p_faddr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_data_o |-> $stable(fault_addr_o));

endmodule

// File: tb/test_page_guard.sv
module test_page_guard;

    localparam int AW = 32;

    typedef struct packed {
        logic        allow;
        logic [2:0]  rights;
        logic        fi;
        logic        fd;
        logic [31:0] code;
        logic [31:0] faddr;
        logic        bad;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] seg = '0;
    logic [1:0] pp = '0;
    logic user_mode = 1'b0;
    logic [1:0] acc = '0;
    logic miss = 1'b0;
    logic [AW-1:0] eff_addr = '0;

    logic rsp_valid, allow, fi, fd, illegal;
    logic [2:0] rights;
    logic [31:0] code;
    logic [AW-1:0] faddr;

    int tests = 0;
    int fails = 0;
    logic [31:0] model_faddr = '0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    page_guard #(.AW(AW)) i_page_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .seg_i         (seg),
        .pp_i          (pp),
        .user_mode_i   (user_mode),
        .acc_i         (acc),
        .miss_i        (miss),
        .eff_addr_i    (eff_addr),
        .rsp_valid_o   (rsp_valid),
        .allow_o       (allow),
        .rights_o      (rights),
        .fault_instr_o (fi),
        .fault_data_o  (fd),
        .code_o        (code),
        .fault_addr_o  (faddr),
        .illegal_o     (illegal)
    );

    function automatic exp_t model(input logic u, input logic [2:0] s, input logic [1:0] p,
                                   input logic [1:0] a, input logic m, input logic [31:0] ea);
        exp_t e;
        logic k, rd, wr, ex, ok;
        e = '0;
        k  = u ? s[2] : s[1];
        ex = !s[0];
        if (k == 1'b0) begin
            rd = 1'b1;
            wr = (p != 2'd3);
        end else begin
            rd = (p == 2'd1) || (p == 2'd2) || (p == 2'd3);
            wr = (p == 2'd2);
        end
        e.rights = {rd, wr, ex};
        ok = (a == 2'd0) ? rd : (a == 2'd1) ? wr : ex;
        if (a == 2'd3) begin
            e.bad = 1'b1;
        end else if (a == 2'd2 && s[0]) begin
            e.fi = 1'b1; e.code = 32'h1000_0000;
        end else if (m) begin
            if (a == 2'd2) begin
                e.fi = 1'b1; e.code = 32'h4000_0000;
            end else begin
                e.fd = 1'b1; e.code = (a == 2'd1) ? 32'h4200_0000 : 32'h4000_0000;
            end
        end else if (!ok) begin
            e.fd = 1'b1; e.code = (a == 2'd1) ? 32'h0A00_0000 : 32'h0800_0000;
        end else begin
            e.allow = 1'b1;
        end
        e.faddr = ea;
        return e;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(input logic u, input logic [2:0] s, input logic [1:0] p,
                         input logic [1:0] a, input logic m, input logic [31:0] ea);
        exp_t e;
        string t;
        @(negedge clk);
        req_valid = 1'b1; user_mode = u; seg = s; pp = p; acc = a; miss = m; eff_addr = ea;
        e = model(u, s, p, a, m, ea);
        if (e.fd) model_faddr = ea;
        e.faddr = model_faddr;
        if (a == 2'd3) t = "R8";
        else if (a == 2'd2 && s[0]) t = "R4";
        else if (m) t = "R6";
        else if (e.fd) t = "R5";
        else if (u != 1'b0 && s[2] != s[1]) t = "R1";
        else if ((u ? s[2] : s[1]) == 1'b1) t = "R3";
        else t = "R2";
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected response", 128'd1, 128'd0);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {allow, rights, fi, fd, code, faddr, illegal},
                          {e.allow, e.rights, e.fi, e.fd, e.code, e.faddr, e.bad});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R10 reset outputs", {rsp_valid, allow, rights, fi, fd, code, faddr, illegal}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int u = 0; u < 2; u++)
            for (int s = 0; s < 8; s++)
                for (int p = 0; p < 4; p++)
                    for (int a = 0; a < 3; a++)
                        drive(u[0], s[2:0], p[1:0], a[1:0], 1'b0, 32'h1000_0000 + (u * 4096) + (s * 256) + (p * 16) + a);

        for (int a = 0; a < 4; a++) begin
            drive(1'b0, 3'b000, 2'd2, a[1:0], 1'b1, 32'hA000_0000 + a);
            drive(1'b1, 3'b001, 2'd2, a[1:0], 1'b1, 32'hB000_0000 + a);
        end

        go_idle();
        @(negedge clk);
        check("R9 idle outputs zero", {rsp_valid, allow, rights, fi, fd, code, illegal}, '0);

        drive(1'b1, 3'b100, 2'd0, 2'd0, 1'b0, 32'hCAFE_0000);
        drive(1'b0, 3'b000, 2'd0, 2'd1, 1'b0, 32'h1234_5678);
        drive(1'b0, 3'b000, 2'd0, 2'd3, 1'b0, 32'h5555_0000);
        go_idle();
        @(negedge clk);
        check("R7 fault address held", {96'd0, faddr}, {96'd0, 32'hCAFE_0000});

        drive(1'b0, 3'b000, 2'd1, 2'd3, 1'b1, 32'h7777_0000);
        go_idle();
        @(negedge clk);
        check("R8 illegal left address", {96'd0, faddr}, {96'd0, 32'hCAFE_0000});
        check("R9 queue drained", {96'd0, 32'(exp_q.size())}, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule